// File: doc/BRIEF.md
# Byte-Programmed Interval Timer Channel

This block is one down-counting timer channel. Software reaches it through two byte-wide ports: a control port and a data port. A control byte either picks the operating behaviour or asks for a snapshot of the running count. Data writes deliver a 16-bit reload value in two bytes, and data reads return a count in two bytes. The counter moves only on cycles where the count-enable input is high. That input is a one-cycle strobe taken from a slower timebase. The single output `tmr_out` is meant to drive an interrupt request line.

Three behaviours are supported, all with binary counting:
- **Terminal-count flag.** The output goes low when the channel is armed and rises when the count runs out.
- **Periodic rate generator.** The counter reloads itself each period and the output dips low once per period.
- **One-time strobe.** The output pulses low once and the counter does not reload.

A snapshot command copies the count into a holding register. The count can then be read without a carry racing between the two byte reads.

Top module: `ctimer_chan`

## Requirements
- R1: After reset, `tmr_out` is 1, the counter is idle, and a data-port read returns 0x00 (the low byte of a zero count).
- R2: A control byte is decoded only when bits [7:6] are 00 and bit 0 is 0. Bits [5:4] = 00 make it a snapshot command. Any other value of [5:4] makes it a behaviour select, where bits [3:1] = 000 select terminal-count, 010 select rate generator and 100 select one-time strobe. Any other control byte changes nothing: the output, the count and the pending state all stay as they were.
- R3: A reload value is taken as two data writes, low byte first. Counting starts only after the high byte. A behaviour-select byte returns the write sequencer to the low byte. A snapshot command leaves the write sequencer alone.
- R4: In terminal-count behaviour, `tmr_out` drops to 0 on the select byte and again whenever a count is loaded. It rises on the tick that brings the count to 0 and then stays 1 while the counter keeps decrementing and wrapping.
- R5: In terminal-count behaviour, writing a new count re-arms the channel at once, even while it is running. A reload value of 0 counts as 65536 ticks.
- R6: In rate-generator behaviour with reload N ≥ 2, the output is 1 except for the one tick interval in which the count is 1. The count then goes back to N, giving a period of N ticks (0 means 65536).
- R7: In rate-generator behaviour, a count written while the channel is running does not disturb the current period. The new value takes effect at the next reload.
- R8: In one-time strobe behaviour, after a load of N the output goes low for one tick interval when the count reaches 0. The counter does not reload; it keeps decrementing and wrapping with the output held at 1.
- R9: A snapshot captures the count as it stood before any decrement in the same cycle. The next two data reads return the captured low byte and then the captured high byte. After that, reads return the live count, low byte then high byte.
- R10: A snapshot command is ignored while an earlier snapshot is still unread. A behaviour-select byte discards a pending snapshot.
- R11: The count changes only on a tick (count-enable high) while the channel is running, or on a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | One-cycle count tick |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 1 = control port, 0 = data port |
| wr_data | input | BYTE_W | Write byte |
| rd_en | input | 1 | Data-port read strobe; advances the byte pointer |
| rd_data | output | BYTE_W | Data-port read byte |
| tmr_out | output | 1 | Timer output to interrupt line |

## Verification
The snapshot command and a count tick can fall on the same clock edge. This collision is where a naive design loses or corrupts a value. The bench provokes it by driving the snapshot control byte and `cnt_en` in the same cycle, on a counter that is known to be running. It then judges the result twice: the captured value must equal the count from before the tick, and the live count read afterwards must be exactly one lower. A second overlap covered is a rate-generator reload landing while a new count is half-written or just written. The bench checks that the period in progress completes unchanged.

// File: rtl/ctimer_pkg.sv
// Shared types for the interval timer channel.
package ctimer_pkg;
    typedef enum logic [1:0] {
        MD_TERM   = 2'd0,
        MD_RATE   = 2'd1,
        MD_STROBE = 2'd2
    } md_e;
endpackage

// File: rtl/ctimer_decode.sv
// Control/data write decoder.
// Turns a port write into one-cycle strobes: snapshot, behaviour select or data byte.
// Assumes BYTE_W >= 8. Control fields sit in the low eight bits.
module ctimer_decode
    import ctimer_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              latch_cmd,
    output logic              mode_set,
    output md_e               new_mode,
    output logic              data_wr
);
    logic ctl_ok;
    logic md_ok;

    // Channel field must be zero and binary counting requested.
    assign ctl_ok = wr_en && wr_sel && (wr_data[7:6] == 2'b00) && !wr_data[0];

    // Map the behaviour field; unknown codes are rejected.
    always_comb begin
        md_ok    = 1'b1;
        new_mode = MD_TERM;
        case (wr_data[3:1])
            3'b000:  new_mode = MD_TERM;
            3'b010:  new_mode = MD_RATE;
            3'b100:  new_mode = MD_STROBE;
            default: md_ok    = 1'b0;
        endcase
    end

    assign latch_cmd = ctl_ok && (wr_data[5:4] == 2'b00);
    assign mode_set  = ctl_ok && (wr_data[5:4] != 2'b00) && md_ok;
    assign data_wr   = wr_en && !wr_sel;
endmodule

// File: rtl/ctimer_loadseq.sv
// Reload byte sequencer.
// Collects low then high byte and holds the reload value.
// Assumes the behaviour-select and data strobes are never high together.
module ctimer_loadseq #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_set,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_byte,
    output logic              load_stb,
    output logic [CNT_W-1:0]  ld_val,
    output logic [CNT_W-1:0]  reload_q
);
    logic              hi_pend;
    logic [BYTE_W-1:0] lo_q;

    // Track which byte comes next and keep the assembled reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_pend  <= 1'b0;
            lo_q     <= '0;
            reload_q <= '0;
        end else if (mode_set) begin
            hi_pend <= 1'b0;
        end else if (data_wr) begin
            if (hi_pend) begin
                reload_q <= {data_byte, lo_q};
                hi_pend  <= 1'b0;
            end else begin
                lo_q    <= data_byte;
                hi_pend <= 1'b1;
            end
        end
    end

    assign load_stb = data_wr && hi_pend;
    assign ld_val   = {data_byte, lo_q};
endmodule

// File: rtl/ctimer_core.sv
// Down-counter and output shaper for the three behaviours.
// A new count loads on the high-byte write. The exception is rate mode
// while running, where the stored reload is used at the period end.
module ctimer_core
    import ctimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             mode_set,
    input  md_e              new_mode,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] count_q,
    output logic             out_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    md_e  mode_q;
    logic run_q;
    logic fired_q;

    // Behaviour select, load and tick handling, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MD_TERM;
            run_q   <= 1'b0;
            fired_q <= 1'b0;
            count_q <= '0;
            out_q   <= 1'b1;
        end else if (mode_set) begin
            mode_q  <= new_mode;
            run_q   <= 1'b0;
            fired_q <= 1'b0;
            out_q   <= (new_mode != MD_TERM);
        end else if (load_stb && !(mode_q == MD_RATE && run_q)) begin
            count_q <= ld_val;
            run_q   <= 1'b1;
            fired_q <= 1'b0;
            out_q   <= (mode_q != MD_TERM);
        end else if (run_q && cnt_en) begin
            case (mode_q)
                MD_RATE: begin
                    if (count_q == ONE) begin
                        count_q <= reload_q;
                        out_q   <= 1'b1;
                    end else begin
                        count_q <= count_q - ONE;
                        if (count_q == TWO) out_q <= 1'b0;
                    end
                end
                MD_STROBE: begin
                    count_q <= count_q - ONE;
                    if (count_q == ONE && !fired_q) begin
                        out_q   <= 1'b0;
                        fired_q <= 1'b1;
                    end else begin
                        out_q <= 1'b1;
                    end
                end
                default: begin
                    count_q <= count_q - ONE;
                    if (count_q == ONE) out_q <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/ctimer_latch.sv
// Count snapshot register and read byte pointer.
// Assumes the snapshot takes priority over a read in the same cycle.
module ctimer_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_set,
    input  logic             latch_cmd,
    input  logic             rd_en,
    input  logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] latched_q,
    output logic             lat_v,
    output logic             rd_hi
);
    // Capture the count once per snapshot and step the read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched_q <= '0;
            lat_v     <= 1'b0;
            rd_hi     <= 1'b0;
        end else if (mode_set) begin
            lat_v <= 1'b0;
            rd_hi <= 1'b0;
        end else if (latch_cmd) begin
            if (!lat_v) begin
                latched_q <= count_q;
                lat_v     <= 1'b1;
                rd_hi     <= 1'b0;
            end
        end else if (rd_en) begin
            rd_hi <= !rd_hi;
            if (rd_hi) lat_v <= 1'b0;
        end
    end
endmodule

// File: rtl/ctimer_chan.sv
// Interval timer channel top.
// Wires the decoder, reload sequencer, counter core and snapshot path,
// and selects the read byte.
module ctimer_chan
    import ctimer_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              tmr_out
);
    localparam int CNT_W = 2 * BYTE_W;

    logic             latch_cmd;
    logic             mode_set;
    md_e              new_mode;
    logic             data_wr;
    logic             load_stb;
    logic [CNT_W-1:0] ld_val;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] latched_q;
    logic             lat_v;
    logic             rd_hi;
    logic [CNT_W-1:0] rd_word;

    ctimer_decode #(.BYTE_W(BYTE_W)) u_dec (
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .latch_cmd(latch_cmd), .mode_set(mode_set),
        .new_mode(new_mode), .data_wr(data_wr)
    );

    ctimer_loadseq #(.BYTE_W(BYTE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .data_wr(data_wr),
        .data_byte(wr_data), .load_stb(load_stb), .ld_val(ld_val),
        .reload_q(reload_q)
    );

    ctimer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_set(mode_set),
        .new_mode(new_mode), .load_stb(load_stb), .ld_val(ld_val),
        .reload_q(reload_q), .count_q(count_q), .out_q(tmr_out)
    );

    ctimer_latch #(.CNT_W(CNT_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .latch_cmd(latch_cmd),
        .rd_en(rd_en), .count_q(count_q), .latched_q(latched_q),
        .lat_v(lat_v), .rd_hi(rd_hi)
    );

    // Captured word while a snapshot is pending, live count otherwise.
    assign rd_word = lat_v ? latched_q : count_q;
    assign rd_data = rd_hi ? rd_word[CNT_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
endmodule

// File: rtl/ctimer_chk.sv
// Temporal checks for the interval timer channel, bound into the top.
module ctimer_chk #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic              rd_en,
    input logic [BYTE_W-1:0] rd_data,
    input logic              tmr_out,
    input logic [CNT_W-1:0]  count_q,
    input logic              lat_v
);
    p_term_sel_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && wr_data[7:0] == 8'h30) |=> !tmr_out);

    p_rate_sel_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && wr_data[7:0] == 8'h34) |=> tmr_out);

    p_strobe_sel_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && wr_data[7:0] == 8'h38) |=> tmr_out);

    p_idle_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_en) |=> $stable(count_q));

    p_out_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tmr_out) |-> ($past(cnt_en) || $past(wr_en)));

    p_bad_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && wr_data[7:6] != 2'b00 && !cnt_en) |=> $stable(tmr_out));

    p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_v && !wr_en && !rd_en) |=> $stable(rd_data));
endmodule

bind ctimer_chan ctimer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .tmr_out(tmr_out),
    .count_q(count_q), .lat_v(lat_v)
);

// File: tb/test_ctimer_chan.sv
module test_ctimer_chan;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       tmr_out;

    int checks = 0;
    int errs   = 0;

    always #2 clk = ~clk;

    ctimer_chan i_ctimer_chan (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .tmr_out(tmr_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int n);
        wr(1'b0, n[7:0]);
        wr(1'b0, n[15:8]);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            cnt_en = 1'b1;
            repeat (n) @(negedge clk);
            cnt_en = 1'b0;
        end
    endtask

    task automatic rd_byte(output logic [7:0] v);
        v = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_word(output int v);
        logic [7:0] lo, hi;
        rd_byte(lo);
        rd_byte(hi);
        v = {16'h0, hi, lo};
    endtask

    task automatic snap(output int v);
        wr(1'b1, 8'h00);
        rd_word(v);
    endtask

    function automatic int term_cnt(int n, int t);
        return (n - t) & 32'hFFFF;
    endfunction
    function automatic int term_out(int n, int t);
        int nn = (n == 0) ? 65536 : n;
        return (t >= nn) ? 1 : 0;
    endfunction
    function automatic int rate_cnt(int n, int t);
        int nn = (n == 0) ? 65536 : n;
        return (nn - (t % nn)) & 32'hFFFF;
    endfunction
    function automatic int rate_out(int n, int t);
        return (rate_cnt(n, t) == 1) ? 0 : 1;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int v, v2, t, n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 out", tmr_out, 1);
        chk("R1 rd", rd_data, 0);

        // R4 select drops output; R3 low byte alone does not start counting
        wr(1'b1, 8'h30);
        chk("R4 select low", tmr_out, 0);
        wr(1'b0, 8'h05);
        ticks(3);
        chk("R3 no start out", tmr_out, 0);
        snap(v);
        chk("R3 no start count", v, 0);
        wr(1'b0, 8'h00);           // high byte: count 5 loads
        ticks(4);
        chk("R4 before tc", tmr_out, 0);
        ticks(1);
        chk("R4 at tc", tmr_out, 1);
        ticks(3);
        chk("R4 stays high", tmr_out, 1);
        snap(v);
        chk("R4 wraps", v, 65533);

        // R2 ignored control bytes: other channel, BCD, unknown mode
        wr(1'b1, 8'h70);
        wr(1'b1, 8'h31);
        wr(1'b1, 8'h3A);
        chk("R2 out kept", tmr_out, 1);
        snap(v);
        chk("R2 count kept", v, 65533);

        // R5 re-arm with zero = 65536
        load(0);
        chk("R5 rearm low", tmr_out, 0);
        ticks(65535);
        chk("R5 one short", tmr_out, 0);
        ticks(1);
        chk("R5 full span", tmr_out, 1);

        // R3 select byte resets sequencer
        wr(1'b1, 8'h30);
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h30);
        load(7);
        snap(v);
        chk("R3 seq reset", v, 7);

        // R9 same-cycle snapshot and tick
        load(1000);
        ticks(10);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h00; cnt_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cnt_en = 1'b0;
        rd_word(v);
        chk("R9 pre-tick capture", v, 990);
        rd_word(v);
        chk("R9 live after", v, 989);

        // R10 second snapshot while pending ignored
        wr(1'b1, 8'h00);
        ticks(5);
        wr(1'b1, 8'h00);
        rd_word(v);
        chk("R10 first kept", v, 989);
        snap(v);
        chk("R10 fresh", v, 984);
        // R10 select discards pending snapshot
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h30);
        rd_word(v);
        chk("R10 discard", v, 984);

        // R6 rate pattern, N=5
        wr(1'b1, 8'h34);
        load(5);
        for (int k = 1; k <= 12; k++) begin
            ticks(1);
            chk("R6 pattern", tmr_out, rate_out(5, k));
        end
        // R7 new count during period: count now 3
        load(8);
        ticks(2);
        chk("R7 old period low", tmr_out, 0);
        ticks(1);
        snap(v);
        chk("R7 new reload", v, 8);
        ticks(6);
        chk("R7 new period high", tmr_out, 1);
        ticks(1);
        chk("R7 new period low", tmr_out, 0);

        // R8 one-time strobe
        wr(1'b1, 8'h38);
        chk("R8 select high", tmr_out, 1);
        load(3);
        ticks(2);
        chk("R8 before", tmr_out, 1);
        ticks(1);
        chk("R8 pulse", tmr_out, 0);
        ticks(1);
        chk("R8 after", tmr_out, 1);
        ticks(10);
        chk("R8 no repeat", tmr_out, 1);
        snap(v);
        chk("R8 no reload", v, 65525);

        // R11 no tick: count holds
        ticks(0);
        repeat (20) @(negedge clk);
        snap(v2);
        chk("R11 hold", v2, 65525);

        // Random trials against model functions
        for (int tr = 0; tr < 20; tr++) begin
            n = 2 + int'($urandom_range(598));
            t = int'($urandom_range(1500));
            if (tr % 2 == 0) begin
                wr(1'b1, 8'h30);
                load(n);
                ticks(t);
                chk("R4 rand out", tmr_out, term_out(n, t));
                snap(v);
                chk("R5 rand count", v, term_cnt(n, t));
            end else begin
                wr(1'b1, 8'h34);
                load(n);
                ticks(t);
                chk("R6 rand out", tmr_out, rate_out(n, t));
                snap(v);
                chk("R6 rand count", v, rate_cnt(n, t));
            end
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule